// File: doc/BRIEF.md
# Instruction Cache Line Parity Checker

This block audits one set of an instruction cache after an error has been reported. It walks every way of the set that a line index selects. For each way it first reads the raw tag. When a data check is requested, it then reads the data beats of that way. On every read it recomputes the protection bits and compares them with the stored copies. Each read takes one cycle. The block drives the read address, and the cache-array read port answers in the same cycle on the tag and data inputs.

Mismatches are collected in a 32-bit result word with two flags. Bit 29 means that some tag protection check failed. Bit 28 means that some data protection check failed. Both flags are the OR over every read of the sweep. A single-cycle `start` pulse launches a sweep, and a single-cycle `done` pulse ends it. The result is cleared when a sweep is accepted and then holds its value until the next accepted start.

Top module: `icache_parity_chk`

## Requirements
- R1: After synchronous active-high reset, `result` is zero, `done` is low and `rd_valid` is low.
- R2: Tag-word-high bit 29 is the line valid bit and bit 27 is its protection copy. Whenever the two differ, result bit 29 is set, including for an invalid line.
- R3: For a valid line, tag-word-low bit 10 must equal the XOR of tag-word-low bits 23:0 with bits 11 and 10 taken as zero. A mismatch sets result bit 29.
- R4: For a valid line, tag-word-low bit 11 must equal the XOR of tag-word-low bits 63:24. A mismatch sets result bit 29.
- R5: For an invalid line (bit 29 low and bit 27 low), tag-word-low bits 10 and 11 are not checked, and the read adds no flag.
- R6: On a data beat, side-word bit 16 must equal the XOR of side-word bits 15:8, which are the predecode bits. A mismatch sets result bit 28. Side-word bits 19:17 are not checked.
- R7: Side-word bits 7:4 hold the even parity of each byte of `inst_a`, and bits 3:0 hold the same for `inst_b`. In both fields the parity of the most significant byte sits in the highest bit. Any mismatch sets result bit 28.
- R8: Flags accumulate by OR over all 4 ways and all 4 beats of each way. A single failing read anywhere in the sweep sets its flag. All result bits other than 29 and 28 stay zero.
- R9: A sweep reads way 0 to way 3 in order. Each way gets one tag read (`rd_is_data` low) and then, when data checking is on, beats 0 to 3 (`rd_is_data` high). The address is (way << 13) | line_idx | (beat << 3), with the beat term absent on tag reads. There is one read per cycle and no gaps, so a sweep has 20 reads with data checking and 4 without.
- R10: `data_chk` is sampled only when a start is accepted. When it is low, no data beat is read and result bit 28 stays clear.
- R11: An accepted start clears `result`. `done` pulses for one cycle in the cycle after the last read. `result` then holds until the next accepted start.
- R12: A `start` pulse while a sweep is busy is ignored. The sweep keeps its read count and its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a sweep when idle |
| data_chk | input | 1 | Also read and check data beats; sampled at start |
| line_idx | input | 15 | Set index field OR'd into every read address |
| rd_valid | output | 1 | A cache-array read is issued this cycle |
| rd_is_data | output | 1 | High for a data-beat read, low for a tag read |
| rd_addr | output | 15 | Read address |
| tag_hi | input | 32 | Raw high tag word of the addressed way |
| tag_lo | input | 64 | Raw low tag word of the addressed way |
| side_word | input | 20 | Predecode and parity side word of the addressed beat |
| inst_a | input | 32 | First instruction of the addressed beat |
| inst_b | input | 32 | Second instruction of the addressed beat |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse at the end of a sweep |
| result | output | 32 | Accumulated flags: bit 29 tag, bit 28 data |

## Verification
The assertions assume that the read port answers in the same cycle as `rd_addr` and that `start` is a clean synchronous pulse. They also assume `line_idx` keeps bits 14:13 and 4:3 at zero, so the way and beat fields of the address do not overlap. The stimulus keeps to these limits by using a combinational array model in the bench, set-index values with only bits 12:5 in use, and inputs driven on the falling edge. Flags and handshake are only assumed meaningful from the first clock after reset.

// File: rtl/icp_pkg.sv
package icp_pkg;
  localparam int VLD_BIT      = 29;
  localparam int VLD_PROT_BIT = 27;
  localparam int LO_P0_BIT    = 10;
  localparam int LO_P1_BIT    = 11;
  localparam int LO_SPLIT     = 24;
  localparam int PD_PAR_BIT   = 16;
  localparam int PD_LSB       = 8;
  localparam int IA_PAR_LSB   = 4;
  localparam int IB_PAR_LSB   = 0;

  typedef enum logic [1:0] {SQ_IDLE, SQ_TAG, SQ_DATA} sq_state_e;

  // parity of the lower tag segment, the two stored parity bits excluded
  function automatic logic lo_low_par(input logic [63:0] lo);
    logic [LO_SPLIT-1:0] f;
    f = lo[LO_SPLIT-1:0];
    f[LO_P1_BIT] = 1'b0;
    f[LO_P0_BIT] = 1'b0;
    return ^f;
  endfunction

  function automatic logic lo_high_par(input logic [63:0] lo);
    return ^lo[63:LO_SPLIT];
  endfunction

  // even parity per byte, most significant byte in bit 3
  function automatic logic [3:0] byte_par4(input logic [31:0] w);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = ^w[8*i +: 8];
    return r;
  endfunction

  function automatic logic pd_par(input logic [7:0] p);
    return ^p;
  endfunction
endpackage

// File: rtl/icp_tag_check.sv
module icp_tag_check
  import icp_pkg::*;
(
  input  logic [31:0] tag_hi,
  input  logic [63:0] tag_lo,
  output logic        vld_err,
  output logic        lo0_err,
  output logic        lo1_err,
  output logic        tag_err
);
  logic line_valid;

  assign line_valid = tag_hi[VLD_BIT];
  assign vld_err    = tag_hi[VLD_BIT] ^ tag_hi[VLD_PROT_BIT];
  assign lo0_err    = line_valid & (tag_lo[LO_P0_BIT] ^ lo_low_par(tag_lo));
  assign lo1_err    = line_valid & (tag_lo[LO_P1_BIT] ^ lo_high_par(tag_lo));
  assign tag_err    = vld_err | lo0_err | lo1_err;
endmodule

// File: rtl/icp_beat_check.sv
module icp_beat_check
  import icp_pkg::*;
#(
  parameter int SIDE_W = 20
) (
  input  logic [SIDE_W-1:0] side_word,
  input  logic [31:0]       inst_a,
  input  logic [31:0]       inst_b,
  output logic              pd_err,
  output logic              a_err,
  output logic              b_err,
  output logic              beat_err
);
  assign pd_err   = side_word[PD_PAR_BIT] ^ pd_par(side_word[PD_LSB +: 8]);
  assign a_err    = side_word[IA_PAR_LSB +: 4] != byte_par4(inst_a);
  assign b_err    = side_word[IB_PAR_LSB +: 4] != byte_par4(inst_b);
  assign beat_err = pd_err | a_err | b_err;
endmodule

// File: rtl/icp_sequencer.sv
module icp_sequencer
  import icp_pkg::*;
#(
  parameter int WAYS       = 4,
  parameter int BEATS      = 4,
  parameter int ADDR_W     = 15,
  parameter int WAY_SHIFT  = 13,
  parameter int BEAT_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              data_chk,
  input  logic [ADDR_W-1:0] line_idx,
  output logic              busy,
  output logic              rd_valid,
  output logic              rd_is_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              start_fire,
  output logic              tag_step,
  output logic              data_step,
  output logic              data_mode,
  output logic              done
);
  localparam int WAY_W  = (WAYS  > 1) ? $clog2(WAYS)  : 1;
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [WAY_W-1:0]  LAST_WAY  = WAY_W'(WAYS - 1);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  sq_state_e         st_q;
  logic [WAY_W-1:0]  way_q;
  logic [BEAT_W-1:0] beat_q;
  logic              mode_q;
  logic              done_q;
  logic              last_step;

  assign busy       = st_q != SQ_IDLE;
  assign start_fire = start && st_q == SQ_IDLE;
  assign tag_step   = st_q == SQ_TAG;
  assign data_step  = st_q == SQ_DATA;
  assign rd_valid   = tag_step | data_step;
  assign rd_is_data = data_step;
  assign data_mode  = mode_q;
  assign done       = done_q;

  assign last_step = (tag_step && !mode_q && way_q == LAST_WAY) ||
                     (data_step && beat_q == LAST_BEAT && way_q == LAST_WAY);

  always_comb begin
    rd_addr = (ADDR_W'(way_q) << WAY_SHIFT) | line_idx;
    if (data_step) rd_addr = rd_addr | (ADDR_W'(beat_q) << BEAT_SHIFT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SQ_IDLE;
      way_q  <= '0;
      beat_q <= '0;
      mode_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_step;
      unique case (st_q)
        SQ_IDLE: if (start) begin
          st_q   <= SQ_TAG;
          way_q  <= '0;
          beat_q <= '0;
          mode_q <= data_chk;
        end
        SQ_TAG: begin
          if (mode_q) begin
            st_q   <= SQ_DATA;
            beat_q <= '0;
          end else if (way_q == LAST_WAY) begin
            st_q <= SQ_IDLE;
          end else begin
            way_q <= way_q + 1'b1;
          end
        end
        SQ_DATA: begin
          if (beat_q == LAST_BEAT) begin
            beat_q <= '0;
            if (way_q == LAST_WAY) begin
              st_q <= SQ_IDLE;
            end else begin
              way_q <= way_q + 1'b1;
              st_q  <= SQ_TAG;
            end
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  // R11: completion is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: beats are only read in a sweep launched with data checking
  p_beats_need_mode_r10: assert property (@(posedge clk) disable iff (rst)
    rd_is_data |-> data_mode);

  // R9: in data mode the tag read of a way is followed by its first beat
  p_tag_then_beat0_r9: assert property (@(posedge clk) disable iff (rst)
    (tag_step && data_mode) |=> (data_step && beat_q == '0));

  // R12: a start seen while busy does not restart the walk
  p_busy_start_ignored_r12: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !last_step) |=> busy);
endmodule

// File: rtl/icache_parity_chk.sv
module icache_parity_chk
  import icp_pkg::*;
#(
  parameter int WAYS       = 4,
  parameter int BEATS      = 4,
  parameter int ADDR_W     = 15,
  parameter int WAY_SHIFT  = 13,
  parameter int BEAT_SHIFT = 3,
  parameter int SIDE_W     = 20,
  parameter int RES_W      = 32,
  parameter int TAG_FLAG   = 29,
  parameter int DATA_FLAG  = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              data_chk,
  input  logic [ADDR_W-1:0] line_idx,
  output logic              rd_valid,
  output logic              rd_is_data,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [31:0]       tag_hi,
  input  logic [63:0]       tag_lo,
  input  logic [SIDE_W-1:0] side_word,
  input  logic [31:0]       inst_a,
  input  logic [31:0]       inst_b,
  output logic              busy,
  output logic              done,
  output logic [RES_W-1:0]  result
);
  logic start_fire, tag_step, data_step, data_mode;
  logic vld_err, lo0_err, lo1_err, tag_err;
  logic pd_err, a_err, b_err, beat_err;
  logic tag_hit, data_hit;
  logic [RES_W-1:0] res_q;

  icp_sequencer #(
    .WAYS(WAYS), .BEATS(BEATS), .ADDR_W(ADDR_W),
    .WAY_SHIFT(WAY_SHIFT), .BEAT_SHIFT(BEAT_SHIFT)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .data_chk(data_chk),
    .line_idx(line_idx), .busy(busy), .rd_valid(rd_valid),
    .rd_is_data(rd_is_data), .rd_addr(rd_addr), .start_fire(start_fire),
    .tag_step(tag_step), .data_step(data_step), .data_mode(data_mode),
    .done(done)
  );

  icp_tag_check u_tag (
    .tag_hi(tag_hi), .tag_lo(tag_lo),
    .vld_err(vld_err), .lo0_err(lo0_err), .lo1_err(lo1_err), .tag_err(tag_err)
  );

  icp_beat_check #(.SIDE_W(SIDE_W)) u_beat (
    .side_word(side_word), .inst_a(inst_a), .inst_b(inst_b),
    .pd_err(pd_err), .a_err(a_err), .b_err(b_err), .beat_err(beat_err)
  );

  assign tag_hit  = tag_step  & tag_err;
  assign data_hit = data_step & beat_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
    end else if (start_fire) begin
      res_q <= '0;
    end else begin
      if (tag_hit)  res_q[TAG_FLAG]  <= 1'b1;
      if (data_hit) res_q[DATA_FLAG] <= 1'b1;
    end
  end

  assign result = res_q;

  // R11: an accepted start leaves an empty result
  p_start_clears_r11: assert property (@(posedge clk) disable iff (rst)
    start_fire |=> result == '0);

  // R11: outside a sweep the result does not move
  p_hold_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start_fire) |=> $stable(result));

  // R8: flags are sticky within a sweep
  p_tag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (result[TAG_FLAG] && !start_fire) |=> result[TAG_FLAG]);
  p_data_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (result[DATA_FLAG] && !start_fire) |=> result[DATA_FLAG]);

  // R2: a broken valid-bit copy always reaches the tag flag
  p_vld_flag_r2: assert property (@(posedge clk) disable iff (rst)
    (tag_step && vld_err && !start_fire) |=> result[TAG_FLAG]);

  // R10: a tag-only sweep never ends with the data flag
  p_no_data_flag_r10: assert property (@(posedge clk) disable iff (rst)
    (done && !data_mode) |-> !result[DATA_FLAG]);

  // R8: only the two flag bits can ever be set
  p_flags_only_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(result) == $countones({result[TAG_FLAG], result[DATA_FLAG]}));
endmodule

// File: tb/icache_parity_chk_bench.sv
module icache_parity_chk_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        start, data_chk;
  logic [14:0] line_idx;
  logic        rd_valid, rd_is_data, busy, done;
  logic [14:0] rd_addr;
  logic [31:0] tag_hi, inst_a, inst_b, result;
  logic [63:0] tag_lo;
  logic [19:0] side_word;

  logic [31:0] m_hi [4];
  logic [63:0] m_lo [4];
  logic [19:0] m_sd [4][4];
  logic [31:0] m_a  [4][4];
  logic [31:0] m_b  [4][4];

  int n_tests = 0;
  int n_fail  = 0;

  always #(PERIOD/2) clk = ~clk;

  icache_parity_chk u_icache_parity_chk (
    .clk(clk), .rst(rst), .start(start), .data_chk(data_chk),
    .line_idx(line_idx), .rd_valid(rd_valid), .rd_is_data(rd_is_data),
    .rd_addr(rd_addr), .tag_hi(tag_hi), .tag_lo(tag_lo),
    .side_word(side_word), .inst_a(inst_a), .inst_b(inst_b),
    .busy(busy), .done(done), .result(result)
  );

  // array model answering in the same cycle
  always_comb begin
    tag_hi    = m_hi[rd_addr[14:13]];
    tag_lo    = m_lo[rd_addr[14:13]];
    side_word = m_sd[rd_addr[14:13]][rd_addr[4:3]];
    inst_a    = m_a[rd_addr[14:13]][rd_addr[4:3]];
    inst_b    = m_b[rd_addr[14:13]][rd_addr[4:3]];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit odd_range(input logic [63:0] v, input int lo, input int hi, input bit skip_pb);
    bit p = 0;
    for (int i = lo; i <= hi; i++)
      if (!(skip_pb && (i == 10 || i == 11))) p = p ^ v[i];
    return p;
  endfunction

  function automatic logic [3:0] bytes_even(input logic [31:0] w);
    logic [3:0] r;
    for (int k = 0; k < 4; k++) r[3-k] = odd_range({32'd0, w}, 24 - 8*k, 31 - 8*k, 1'b0);
    return r;
  endfunction

  function automatic logic [63:0] fix_lo(input logic [63:0] lo);
    logic [63:0] r = lo;
    r[10] = odd_range(lo, 0, 23, 1'b1);
    r[11] = odd_range(lo, 24, 63, 1'b0);
    return r;
  endfunction

  function automatic logic [19:0] fix_side(input logic [19:0] s, input logic [31:0] a, input logic [31:0] b);
    logic [19:0] r = s;
    r[16]  = odd_range({56'd0, s[15:8]}, 0, 7, 1'b0);
    r[7:4] = bytes_even(a);
    r[3:0] = bytes_even(b);
    return r;
  endfunction

  function automatic logic [31:0] expect_res(input bit dchk);
    bit tg = 0, dt = 0;
    for (int w = 0; w < 4; w++) begin
      if (m_hi[w][29] != m_hi[w][27]) tg = 1;
      if (m_hi[w][29]) begin
        if (m_lo[w][10] != odd_range(m_lo[w], 0, 23, 1'b1)) tg = 1;
        if (m_lo[w][11] != odd_range(m_lo[w], 24, 63, 1'b0)) tg = 1;
      end
      if (dchk) for (int b = 0; b < 4; b++) begin
        if (m_sd[w][b][16] != odd_range({56'd0, m_sd[w][b][15:8]}, 0, 7, 1'b0)) dt = 1;
        if (m_sd[w][b][7:4] != bytes_even(m_a[w][b])) dt = 1;
        if (m_sd[w][b][3:0] != bytes_even(m_b[w][b])) dt = 1;
      end
    end
    return (32'(tg) << 29) | (32'(dt) << 28);
  endfunction

  task automatic fill_clean();
    for (int w = 0; w < 4; w++) begin
      m_hi[w] = $urandom;
      m_hi[w][27] = m_hi[w][29];
      m_lo[w] = fix_lo({$urandom, $urandom});
      for (int b = 0; b < 4; b++) begin
        m_a[w][b]  = $urandom;
        m_b[w][b]  = $urandom;
        m_sd[w][b] = fix_side(20'($urandom), m_a[w][b], m_b[w][b]);
      end
    end
  endtask

  // one sweep; poke >= 0 raises start again at that read index
  task automatic run_scan(input bit dchk, input int poke, output logic [31:0] res, output int nreads, output bit addr_bad);
    int guard = 0;
    nreads = 0;
    addr_bad = 0;
    @(negedge clk);
    start = 1'b1; data_chk = dchk;
    @(negedge clk);
    start = 1'b0; data_chk = ~dchk;
    while (!done) begin
      if (rd_valid) begin
        int w, s;
        logic [14:0] ea;
        bit ed;
        if (dchk) begin w = nreads / 5; s = nreads % 5; end
        else begin w = nreads; s = 0; end
        ed = (s != 0);
        ea = (15'(w) << 13) | line_idx | (ed ? (15'(s - 1) << 3) : 15'd0);
        if (rd_addr !== ea || rd_is_data !== ed) addr_bad = 1;
        nreads++;
      end
      start = (nreads == poke);
      @(negedge clk);
      guard++;
      if (guard > 100) begin
        check("watchdog-sweep", 32'd0, 32'd1);
        break;
      end
    end
    start = 1'b0;
    res = result;
  endtask

  task automatic sweep_expect(input string req, input bit dchk);
    logic [31:0] r; int n; bit ab;
    run_scan(dchk, -1, r, n, ab);
    check(req, r, expect_res(dchk));
  endtask

  initial begin
    #(PERIOD * 200000);
    check("watchdog", 32'd0, 32'd1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r; int n; bit ab;
    rst = 1'b1; start = 1'b0; data_chk = 1'b0; line_idx = 15'h0AC0;
    fill_clean();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 result", result, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    rst = 1'b0;

    // R9 R8: clean line with data, address order and count
    foreach (m_hi[w]) begin m_hi[w][29] = 1'b1; m_hi[w][27] = 1'b1; end
    run_scan(1'b1, -1, r, n, ab);
    check("R8 clean data sweep", r, 32'd0);
    check("R9 reads with data", n, 20);
    check("R9 address order", {31'd0, ab}, 32'd0);

    // R10: tag-only sweep reads 4 tags and ignores broken beats
    line_idx = 15'h1FE0;
    m_sd[1][2][16] = ~m_sd[1][2][16];
    run_scan(1'b0, -1, r, n, ab);
    check("R10 tag-only result", r, 32'd0);
    check("R10 tag-only reads", n, 4);
    check("R9 tag-only addresses", {31'd0, ab}, 32'd0);
    // R6: same break caught with data checking
    run_scan(1'b1, -1, r, n, ab);
    check("R6 predecode parity", r, 32'h1000_0000);
    // R11: result held after done
    repeat (5) begin @(negedge clk); check("R11 hold", result, 32'h1000_0000); end
    m_sd[1][2][16] = ~m_sd[1][2][16];
    run_scan(1'b1, -1, r, n, ab);
    check("R11 cleared by new start", r, 32'd0);

    // R2: valid copy broken on an invalid line
    m_hi[2][29] = 1'b0; m_hi[2][27] = 1'b1;
    sweep_expect("R2 valid copy invalid line", 1'b0);
    check("R2 flag", result, 32'h2000_0000);
    m_hi[2][27] = 1'b0;
    // R5: invalid line with broken lower-tag parity
    m_lo[2][10] = ~m_lo[2][10]; m_lo[2][11] = ~m_lo[2][11];
    sweep_expect("R5 invalid line ignored", 1'b1);
    check("R5 zero", result, 32'd0);
    m_hi[2][29] = 1'b1; m_hi[2][27] = 1'b1;
    sweep_expect("R3 R4 valid line broken", 1'b0);
    m_lo[2] = fix_lo(m_lo[2]);

    // R3 R4: every lower-tag bit flip on every valid way
    for (int w = 0; w < 4; w++)
      for (int k = 0; k < 64; k++) begin
        m_lo[w][k] = ~m_lo[w][k];
        run_scan(1'b0, -1, r, n, ab);
        check(k < 24 ? "R3 tag low segment" : "R4 tag high segment", r, 32'h2000_0000);
        m_lo[w][k] = ~m_lo[w][k];
      end

    // R6 R8: every side-word bit on every beat; bits 19:17 unchecked
    for (int w = 0; w < 4; w++)
      for (int b = 0; b < 4; b++)
        for (int k = 0; k < 20; k++) begin
          m_sd[w][b][k] = ~m_sd[w][b][k];
          run_scan(1'b1, -1, r, n, ab);
          check("R6 R8 side bit sweep", r, (k <= 16) ? 32'h1000_0000 : 32'd0);
          m_sd[w][b][k] = ~m_sd[w][b][k];
        end

    // R7: every instruction bit of both words
    for (int w = 0; w < 4; w++)
      for (int b = 0; b < 4; b++)
        for (int k = 0; k < 32; k++) begin
          m_a[w][b][k] = ~m_a[w][b][k];
          run_scan(1'b1, -1, r, n, ab);
          check("R7 inst_a byte parity", r, 32'h1000_0000);
          m_a[w][b][k] = ~m_a[w][b][k];
          m_b[w][b][k] = ~m_b[w][b][k];
          run_scan(1'b1, -1, r, n, ab);
          check("R7 inst_b byte parity", r, 32'h1000_0000);
          m_b[w][b][k] = ~m_b[w][b][k];
        end

    // R7: field position, instruction A parity field swapped with B
    m_a[3][0] = 32'h0100_0000; m_b[3][0] = 32'h0000_0000;
    m_sd[3][0] = fix_side(m_sd[3][0], m_a[3][0], m_b[3][0]);
    check("R7 msb byte in bit 7", {28'd0, m_sd[3][0][7:4]}, 32'h8);
    sweep_expect("R7 positioned parity clean", 1'b1);
    m_sd[3][0][7:0] = {m_sd[3][0][3:0], m_sd[3][0][7:4]};
    sweep_expect("R7 swapped fields", 1'b1);
    m_sd[3][0] = fix_side(m_sd[3][0], m_a[3][0], m_b[3][0]);

    // R8: both flags, random mixed faults
    for (int t = 0; t < 40; t++) begin
      fill_clean();
      if (t % 3 == 0) m_lo[t % 4][$urandom_range(0, 63)] ^= 1'b1;
      if (t % 2 == 0) m_sd[$urandom_range(0, 3)][$urandom_range(0, 3)][$urandom_range(0, 16)] ^= 1'b1;
      if (t % 5 == 0) m_hi[(t + 1) % 4][27] ^= 1'b1;
      sweep_expect("R8 mixed faults", t[0]);
    end

    // R12: start pulse in the middle of a sweep is ignored
    fill_clean();
    m_hi[0][27] = ~m_hi[0][29];
    run_scan(1'b1, 7, r, n, ab);
    check("R12 reads unchanged", n, 20);
    check("R12 result kept", r, expect_res(1'b1));
    check("R12 addresses", {31'd0, ab}, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule